// File: doc/BRIEF.md
# Scratchpad Write CRC-16 Generator

This block sits on the device side of a single-wire memory bus. It computes the 16-bit check value that guards a write into a 32-byte scratchpad. Upstream logic has already decoded the bus bits into bytes. It hands each byte over on a valid/ready stream, tagged as the command code, the low target address, the high target address or a data byte. The block folds every accepted command and address byte into the checksum. It folds in a data byte only while the scratchpad still has room.

The low target address gives the starting scratchpad offset, taken from its five low bits. Each data byte moves the offset forward by one. When a data byte lands at offset 31, the write is marked complete. Data that follows it is taken off the stream but has no effect.

When the transfer is closed, the checksum becomes readable only if the write reached the last offset. The block then shows the one's complement of the checksum on a parallel output. It also sends that value back as two bytes on an output valid/ready stream.

Back-pressure works as follows. An input byte is consumed on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only while a transfer is open and neither `xfer_start` nor `xfer_end` is asserted. An output byte is consumed on a cycle where `out_valid` and `out_ready` are both high. Until then the byte is held unchanged.

Top module: `wrsp_crc16`

## Requirements
- R1: The checksum uses the generator x^16 + x^15 + x^2 + 1 in reflected form (feedback constant 0xA001), with each byte entered least significant bit first; fed the ASCII bytes "123456789" from a cleared state, it yields 0xBB3D.
- R2: Asserting `xfer_start` clears the checksum, the offset and the completion state. Bytes from an abandoned earlier transfer have no effect on the next result.
- R3: Accepted bytes enter the checksum in arrival order: tag 0 (command), tag 1 (address low), tag 2 (address high), then tag 3 (data) bytes.
- R4: An accepted address-low byte loads the offset from its bits [4:0]. Each data byte that is counted adds one to the offset.
- R5: A data byte counted at offset 31 marks the write complete. On `xfer_end`, `crc_available` rises in the next cycle only if the write is complete.
- R6: Data bytes accepted after the write is complete are consumed. They change neither the offset nor the checksum.
- R7: While `crc_available` is high, `crc_value` equals the bitwise inverse of the checksum. The output stream sends the inverted low byte first, then the inverted high byte, and then `out_valid` goes low.
- R8: If the transfer ends before offset 31 is written, `crc_available` stays low, `crc_value` reads 0 and `out_valid` never rises.
- R9: `in_ready` is low outside an open transfer and after `xfer_end`. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R10: The address-high byte enters the checksum but does not change the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Opens a write transfer and clears all state |
| xfer_end | input | 1 | Closes the open transfer |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts the input byte |
| in_tag | input | 2 | 0 command, 1 address low, 2 address high, 3 data |
| in_data | input | 8 | Input byte |
| crc_available | output | 1 | Checksum readback permitted |
| crc_value | output | 16 | Inverted checksum, 0 when not available |
| out_valid | output | 1 | Readback byte present |
| out_ready | input | 1 | Consumer takes the readback byte |
| out_data | output | 8 | Readback byte |

## Verification
The hardest situation to reach is a long write that passes the last offset. Data keeps arriving after completion, and a wrong design would silently fold it into the checksum. The stimulus starts transfers at offsets 29, 30 and 31 and sends more data bytes than remain, so the result is correct only if the extra bytes are left out. Other transfers stop one byte short of offset 31, or are abandoned halfway and restarted. Each readback is stalled for several cycles before it is drained.

// File: rtl/wrsp_pkg.sv
package wrsp_pkg;
  typedef enum logic [1:0] {
    TAG_CMD     = 2'd0,
    TAG_ADDR_LO = 2'd1,
    TAG_ADDR_HI = 2'd2,
    TAG_DATA    = 2'd3
  } byte_tag_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/wrsp_crc_engine.sv
module wrsp_crc_engine #(
  parameter int unsigned CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY_REFL = 16'hA001,
  parameter int unsigned DIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift_en,
  input  logic [DIN_W-1:0] din,
  output logic [CRC_W-1:0] crc
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] stage [DIN_W+1];

  assign stage[0] = crc_q;

  // One reflected shift per input bit, least significant bit first.
  for (genvar i = 0; i < DIN_W; i++) begin : g_bit
    logic fb;
    assign fb = stage[i][0] ^ din[i];
    assign stage[i+1] = (stage[i] >> 1) ^ (fb ? POLY_REFL : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        crc_q <= '0;
    else if (clr)      crc_q <= '0;
    else if (shift_en) crc_q <= stage[DIN_W];
  end

  assign crc = crc_q;

  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == '0));
  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !shift_en) |=> $stable(crc));
endmodule

// File: rtl/wrsp_offset_track.sv
module wrsp_offset_track #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned OW = $clog2(DEPTH),
  localparam logic [OW-1:0] LAST = OW'(DEPTH - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load_en,
  input  logic [OW-1:0] load_val,
  input  logic          data_en,
  output logic          data_take,
  output logic [OW-1:0] offset,
  output logic          reached
);
  logic [OW-1:0] off_q;
  logic          done_q;

  assign data_take = data_en && !done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      done_q <= 1'b0;
    end else if (clr) begin
      off_q  <= '0;
      done_q <= 1'b0;
    end else if (load_en) begin
      off_q <= load_val;
    end else if (data_take) begin
      if (off_q == LAST) done_q <= 1'b1;
      else               off_q  <= off_q + 1'b1;
    end
  end

  assign offset  = off_q;
  assign reached = done_q;

  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (reached && !clr) |=> reached);
  a_r6_offset_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (reached && !clr && !load_en) |=> $stable(offset));
  a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (data_take && !clr && !load_en && offset != LAST) |=> (offset == $past(offset) + 1'b1));
endmodule

// File: rtl/wrsp_readout.sv
module wrsp_readout #(
  parameter int unsigned CRC_W = 16,
  parameter int unsigned BW = 8,
  localparam int unsigned NB = CRC_W / BW,
  localparam int unsigned IW = $clog2(NB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             arm,
  input  logic [CRC_W-1:0] crc_in,
  input  logic             out_ready,
  output logic             avail,
  output logic             out_valid,
  output logic [BW-1:0]    out_byte,
  output logic [CRC_W-1:0] crc_tx
);
  logic [CRC_W-1:0] snap_q;
  logic [IW-1:0]    idx_q;
  logic             avail_q;

  assign out_valid = avail_q && (idx_q < IW'(NB));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q  <= '0;
      idx_q   <= '0;
      avail_q <= 1'b0;
    end else if (clr) begin
      snap_q  <= '0;
      idx_q   <= '0;
      avail_q <= 1'b0;
    end else if (arm) begin
      snap_q  <= ~crc_in;
      idx_q   <= '0;
      avail_q <= 1'b1;
    end else if (out_valid && out_ready) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  // Low byte leaves first.
  always_comb begin
    out_byte = '0;
    for (int k = 0; k < NB; k++) begin
      if (idx_q == IW'(k)) out_byte = snap_q[k*BW +: BW];
    end
  end

  assign avail  = avail_q;
  assign crc_tx = avail_q ? snap_q : '0;

  a_r8_valid_needs_avail: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> avail);
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr && !arm) |=> (out_valid && $stable(out_byte)));
endmodule

// File: rtl/wrsp_crc16.sv
module wrsp_crc16 #(
  parameter int unsigned SP_DEPTH = 32,
  parameter int unsigned CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY_REFL = 16'hA001,
  localparam int unsigned OW = $clog2(SP_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_start,
  input  logic             xfer_end,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_tag,
  input  logic [7:0]       in_data,
  output logic             crc_available,
  output logic [CRC_W-1:0] crc_value,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data
);
  import wrsp_pkg::*;

  byte_tag_e     tag;
  logic          active_q;
  logic          accept;
  logic          data_en, data_take, load_en, shift_en, arm;
  logic [OW-1:0] offset;
  logic          reached;
  logic [CRC_W-1:0] crc;

  assign tag      = byte_tag_e'(in_tag);
  assign in_ready = active_q && !xfer_start && !xfer_end;
  assign accept   = in_valid && in_ready;
  assign data_en  = accept && (tag == TAG_DATA);
  assign load_en  = accept && (tag == TAG_ADDR_LO);
  assign shift_en = accept && ((tag != TAG_DATA) || data_take);
  assign arm      = xfer_end && active_q && !xfer_start && reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          active_q <= 1'b0;
    else if (xfer_start) active_q <= 1'b1;
    else if (xfer_end)   active_q <= 1'b0;
  end

  wrsp_crc_engine #(.CRC_W(CRC_W), .POLY_REFL(POLY_REFL), .DIN_W(BYTE_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(xfer_start), .shift_en(shift_en),
    .din(in_data), .crc(crc)
  );

  wrsp_offset_track #(.DEPTH(SP_DEPTH)) u_off (
    .clk(clk), .rst_n(rst_n), .clr(xfer_start), .load_en(load_en),
    .load_val(in_data[OW-1:0]), .data_en(data_en), .data_take(data_take),
    .offset(offset), .reached(reached)
  );

  wrsp_readout #(.CRC_W(CRC_W), .BW(BYTE_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .clr(xfer_start), .arm(arm), .crc_in(crc),
    .out_ready(out_ready), .avail(crc_available), .out_valid(out_valid),
    .out_byte(out_data), .crc_tx(crc_value)
  );

  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !in_ready);
  a_r8_avail_needs_reach: assert property (@(posedge clk) disable iff (!rst_n)
    crc_available |-> reached);
  a_r10_addr_hi_keeps_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && tag == TAG_ADDR_HI && !xfer_start) |=> $stable(offset));
endmodule

// File: tb/sim_wrsp_crc16.sv
`timescale 1ns/1ps
module sim_wrsp_crc16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_start = 1'b0, xfer_end = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_tag = 2'd0;
  logic [7:0] in_data = 8'd0;
  logic crc_available;
  logic [15:0] crc_value;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [7:0] out_data;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  wrsp_crc16 u0 (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_end(xfer_end),
    .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag), .in_data(in_data),
    .crc_available(crc_available), .crc_value(crc_value),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] m_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[0] ^ d[i];
      r = r >> 1;
      if (fb) r = r ^ 16'hA001;
    end
    return r;
  endfunction

  // Monitor: compares each readback byte with the scoreboard.
  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) check("R7 unexpected byte", {24'd0, out_data}, 32'hFFFF_FFFF);
      else check("R7 readback byte", {24'd0, out_data}, {24'd0, exp_q.pop_front()});
    end
  end

  task automatic pulse_start();
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  task automatic send(input logic [1:0] t, input logic [7:0] b);
    in_valid = 1'b1; in_tag = t; in_data = b;
    #0;
    check("R9 ready in open transfer", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_xfer(input logic [7:0] alo, input logic [7:0] ahi,
                          input int ndata, input int seed, input int stall);
    logic [15:0] c = 16'h0000;
    logic [4:0] off = alo[4:0];
    bit done = 0;
    pulse_start();
    send(2'd0, 8'h0F); c = m_step(c, 8'h0F);
    send(2'd1, alo);   c = m_step(c, alo);
    send(2'd2, ahi);   c = m_step(c, ahi);
    for (int k = 0; k < ndata; k++) begin
      logic [7:0] d = 8'(seed * 7 + k * 13 + 1);
      send(2'd3, d);
      if (!done) begin
        c = m_step(c, d);
        if (off == 5'd31) done = 1; else off = off + 5'd1;
      end
    end
    xfer_end = 1'b1;
    @(negedge clk);
    xfer_end = 1'b0;
    check("R9 ready low after end", {31'd0, in_ready}, 32'd0);
    check("R5 R8 available", {31'd0, crc_available}, {31'd0, done});
    if (done) begin
      check("R7 inverted value", {16'd0, crc_value}, {16'd0, ~c});
      exp_q.push_back(~c[7:0]);
      exp_q.push_back(~c[15:8]);
      for (int s = 0; s < stall; s++) begin
        check("R9 stalled valid", {31'd0, out_valid}, 32'd1);
        check("R9 stalled byte", {24'd0, out_data}, {24'd0, ~c[7:0]});
        @(negedge clk);
      end
      out_ready = 1'b1;
      repeat (2) @(negedge clk);
      check("R7 valid drops after two bytes", {31'd0, out_valid}, 32'd0);
      out_ready = 1'b0;
      check("R7 all bytes seen", exp_q.size(), 32'd0);
    end else begin
      check("R8 no valid", {31'd0, out_valid}, 32'd0);
      check("R8 value zero", {16'd0, crc_value}, 32'd0);
    end
  endtask

  initial begin
    logic [15:0] mc = 16'h0000;
    repeat (3) @(negedge clk);
    check("R9 reset ready", {31'd0, in_ready}, 32'd0);
    check("R8 reset available", {31'd0, crc_available}, 32'd0);
    check("R8 reset valid", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 9; i++) mc = m_step(mc, 8'(8'h31 + i));
    check("R1 model check value", {16'd0, mc}, 32'h0000BB3D);
    run_xfer(8'h1F, 8'h00, 1, 1, 0);      // R1 R3 single byte at offset 31
    run_xfer(8'h00, 8'h00, 32, 2, 3);     // R4 full scratchpad
    run_xfer(8'hFD, 8'h00, 6, 3, 2);      // R6 extra bytes after 31
    run_xfer(8'h1E, 8'h00, 5, 4, 0);      // R6
    run_xfer(8'h05, 8'h00, 3, 5, 0);      // R8 short write
    run_xfer(8'h01, 8'h00, 30, 6, 0);     // R8 stops at offset 30
    run_xfer(8'h3C, 8'hFF, 4, 7, 1);      // R10 address high ignored for offset
    // R2: abandoned transfer, then restart
    pulse_start();
    send(2'd0, 8'h0F); send(2'd1, 8'h1F); send(2'd3, 8'hAA);
    run_xfer(8'h1A, 8'h12, 6, 8, 4);
    run_xfer(8'h10, 8'h00, 16, 9, 0);     // R3 R4 mid start
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule